// File: doc/BRIEF.md
# Decimal-Exponent Target Alignment Unit

This unit rescales a decimal-exponent floating-point operand so that its exponent matches a requested target exponent. The target is a 12-bit excess-2048 value, wider than the operand's own exponent field. The operand exponent is first rebased into that same excess-2048 domain. The unit then walks the operand toward the target one decade per clock. When the operand exponent is too large, it multiplies the mantissa by ten and lowers the exponent by one. When the exponent is too small, it divides the mantissa by ten and raises the exponent by one.

Two modes are offered. In ordinary mode the result stays a valid floating-point value: the digit discarded by the final division is rounded half-up, and a multiply that no longer fits saturates the mantissa and raises an overflow flag. In extensible mode the unit behaves like integer hardware: divisions truncate, and a multiply that overflows wraps modulo the mantissa width. In extensible mode a wrap raises a trap request only when integer-overflow trapping is enabled.

The unit is used after the arithmetic step of a targeted fixed-point operation. It returns a value that carries the intended scale factor as its exponent.

Top module: `dex_target_align`

## Requirements
- R1: At start, the operand exponent (excess EXP_BIAS) is rebased by adding 2048-EXP_BIAS. When done is high, out_exp equals tgt_exp, the 12-bit excess-2048 target.
- R2: While the current exponent is above the target, each clock multiplies the mantissa by ten and lowers the exponent by one. An alignment of N steps raises done N+1 clocks after the edge that samples start. With no steps, done comes 1 clock after that edge.
- R3: While the current exponent is below the target, each clock divides the mantissa by ten and raises the exponent by one.
- R4: In ordinary mode (ext_mode=0), only the last division rounds: a remainder of 5 or more adds one to the quotient. Earlier divisions truncate.
- R5: In extensible mode (ext_mode=1), every division truncates.
- R6: In ordinary mode, a multiply whose result exceeds 2^MANT_W-1 saturates the mantissa to all ones and sets ovf. ovf stays set until the next accepted start.
- R7: In extensible mode, an overflowing multiply keeps the product modulo 2^MANT_W, and ovf stays 0.
- R8: trap_req is high in the done cycle only when ext_mode=1, trap_en=1 and at least one multiply wrapped. It is never high in ordinary mode.
- R9: When a division leaves a zero mantissa, the exponent jumps straight to the target, and done follows on the next clock.
- R10: done is a one-clock pulse. A start that arrives while an alignment is in progress is ignored.
- R11: After reset, done, ovf and trap_req are 0, and out_mant and out_exp are 0.
- R12: out_sign carries the sign captured at start, unchanged by alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an alignment with the presented operand |
| in_sign | input | 1 | Operand sign |
| in_exp | input | EXP_W | Operand exponent, excess EXP_BIAS |
| in_mant | input | MANT_W | Operand mantissa |
| tgt_exp | input | 12 | Target exponent, excess-2048 |
| ext_mode | input | 1 | 1 = extensible (integer-like) mode |
| trap_en | input | 1 | Integer-overflow trap enable |
| out_sign | output | 1 | Result sign |
| out_mant | output | MANT_W | Aligned mantissa |
| out_exp | output | 12 | Current exponent, excess-2048 |
| done | output | 1 | One-clock completion pulse |
| ovf | output | 1 | Ordinary-mode overflow (saturated) |
| trap_req | output | 1 | Extensible-mode overflow trap request |

## Verification
The bench builds the unit with its default parameters: a 39-bit mantissa and an 8-bit excess-128 exponent, the medium format. With these values, overflow is reached in one or two multiplications from a twelve-digit operand, and both edges of the rebased exponent range are reachable with short step counts. The 39-bit width also gives exact known wrap values, such as 10^12 mod 2^39. It places the rounding corners on small decimal operands, where intermediate truncation and final rounding give visibly different answers.

// File: rtl/dex_align_pkg.sv
package dex_align_pkg;
  localparam int TGT_W    = 12;
  localparam int TGT_BIAS = 2048;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } align_st_e;
endpackage

// File: rtl/dex_align_mul10.sv
module dex_align_mul10 #(
  parameter int MANT_W = 39
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic              wrap_i,
  output logic [MANT_W-1:0] mant_o,
  output logic              over_o
);
  localparam int PW = MANT_W + 4;

  logic [PW-1:0] prod;

  always_comb begin
    // ten = eight plus two: two shifted copies, one adder
    prod   = ({4'b0000, mant_i} << 3) + ({4'b0000, mant_i} << 1);
    over_o = |prod[PW-1:MANT_W];
    if (over_o && !wrap_i) mant_o = '1;
    else                   mant_o = prod[MANT_W-1:0];
  end
endmodule

// File: rtl/dex_align_div10.sv
module dex_align_div10 #(
  parameter int MANT_W = 39
) (
  input  logic [MANT_W-1:0] mant_i,
  input  logic              round_i,
  output logic [MANT_W-1:0] mant_o
);
  localparam logic [MANT_W-1:0] TEN  = MANT_W'(10);
  localparam logic [MANT_W-1:0] FIVE = MANT_W'(5);
  localparam logic [MANT_W-1:0] ONE  = MANT_W'(1);

  logic [MANT_W-1:0] quo;
  logic [MANT_W-1:0] rem;

  always_comb begin
    quo = mant_i / TEN;
    rem = mant_i - quo * TEN;
    // quo <= max/10, so adding one cannot overflow
    if (round_i && (rem >= FIVE)) mant_o = quo + ONE;
    else                          mant_o = quo;
  end
endmodule

// File: rtl/dex_target_align.sv
module dex_target_align
  import dex_align_pkg::*;
#(
  parameter int MANT_W   = 39,
  parameter int EXP_W    = 8,
  parameter int EXP_BIAS = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 in_sign,
  input  logic [EXP_W-1:0]     in_exp,
  input  logic [MANT_W-1:0]    in_mant,
  input  logic [TGT_W-1:0]     tgt_exp,
  input  logic                 ext_mode,
  input  logic                 trap_en,
  output logic                 out_sign,
  output logic [MANT_W-1:0]    out_mant,
  output logic [TGT_W-1:0]     out_exp,
  output logic                 done,
  output logic                 ovf,
  output logic                 trap_req
);
  localparam logic [TGT_W-1:0] REBIAS = TGT_W'(TGT_BIAS - EXP_BIAS);
  localparam logic [TGT_W-1:0] E_ONE  = TGT_W'(1);

  align_st_e         st_q, st_d;
  logic [TGT_W-1:0]  cur_q, cur_d, tgt_q;
  logic [MANT_W-1:0] mant_q, mant_d;
  logic              sign_q, ext_q, trp_q;
  logic              ovf_q, ovf_d, wrap_q, wrap_d, done_q, done_d;

  logic              load_en, step_en;
  logic              go_down, last_div;
  logic [MANT_W-1:0] mul_m, div_m;
  logic              mul_over;

  dex_align_mul10 #(.MANT_W(MANT_W)) u_mul (
    .mant_i (mant_q),
    .wrap_i (ext_q),
    .mant_o (mul_m),
    .over_o (mul_over)
  );

  dex_align_div10 #(.MANT_W(MANT_W)) u_div (
    .mant_i  (mant_q),
    .round_i (!ext_q && last_div),
    .mant_o  (div_m)
  );

  // next-state logic
  always_comb begin
    load_en  = (st_q == ST_IDLE) && start;
    step_en  = (st_q == ST_RUN) && (cur_q != tgt_q);
    go_down  = cur_q > tgt_q;
    last_div = (cur_q + E_ONE) == tgt_q;

    st_d   = st_q;
    cur_d  = cur_q;
    mant_d = mant_q;
    ovf_d  = ovf_q;
    wrap_d = wrap_q;
    done_d = 1'b0;

    if (load_en) begin
      st_d   = ST_RUN;
      cur_d  = {{(TGT_W-EXP_W){1'b0}}, in_exp} + REBIAS;
      mant_d = in_mant;
      ovf_d  = 1'b0;
      wrap_d = 1'b0;
    end else if (st_q == ST_RUN) begin
      if (!step_en) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end else if (go_down) begin
        mant_d = mul_m;
        cur_d  = cur_q - E_ONE;
        if (mul_over) begin
          if (ext_q) wrap_d = 1'b1;
          else       ovf_d  = 1'b1;
        end
      end else begin
        mant_d = div_m;
        cur_d  = (div_m == '0) ? tgt_q : cur_q + E_ONE;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      tgt_q  <= '0;
      mant_q <= '0;
      sign_q <= 1'b0;
      ext_q  <= 1'b0;
      trp_q  <= 1'b0;
      ovf_q  <= 1'b0;
      wrap_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      mant_q <= mant_d;
      ovf_q  <= ovf_d;
      wrap_q <= wrap_d;
      done_q <= done_d;
      if (load_en) begin
        tgt_q  <= tgt_exp;
        sign_q <= in_sign;
        ext_q  <= ext_mode;
        trp_q  <= trap_en;
      end
    end
  end

  assign out_sign = sign_q;
  assign out_mant = mant_q;
  assign out_exp  = cur_q;
  assign done     = done_q;
  assign ovf      = ovf_q;
  assign trap_req = done_q && wrap_q && trp_q;

  // R10: completion is a single-clock pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: captured target is not disturbed while running
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) |=> $stable(tgt_q));
  // R1: exponent matches the target at completion
  a_r1_exp_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_exp == tgt_q));
  // R2: each downward step lowers the exponent by exactly one
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cur_q > tgt_q) |=> (cur_q == $past(cur_q) - E_ONE));
  // R3, R9: upward steps add one or jump to the target
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cur_q < tgt_q) |=>
      (cur_q == $past(cur_q) + E_ONE || cur_q == tgt_q));
  // R8: trap only in extensible mode with trapping on
  a_r8_trap_mode: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (ext_q && trp_q && done));
  // R7: extensible mode never reports saturation overflow
  a_r7_no_ovf_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q |-> !ovf);
endmodule

// File: tb/dex_target_align_bench.sv
`timescale 1ns/1ps
module dex_target_align_bench;
  localparam int MW = 39;
  localparam logic [MW-1:0] MAXM = '1;

  typedef struct packed {
    logic          sg;
    logic [7:0]    ex;
    logic [MW-1:0] mt;
    logic [11:0]   tg;
    logic          ext;
    logic          trp;
    logic [MW-1:0] emt;
    logic          eovf;
    logic          etrp;
    logic [15:0]   ecyc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd128, 39'd12345,        12'd2048, 1'b0, 1'b0, 39'd12345,        1'b0, 1'b0, 16'd1},
    '{1'b1, 8'd131, 39'd7,            12'd2048, 1'b0, 1'b0, 39'd7000,         1'b0, 1'b0, 16'd4},
    '{1'b0, 8'd128, 39'd12355,        12'd2050, 1'b0, 1'b0, 39'd124,          1'b0, 1'b0, 16'd3},
    '{1'b0, 8'd128, 39'd12344,        12'd2049, 1'b0, 1'b0, 39'd1234,         1'b0, 1'b0, 16'd2},
    '{1'b1, 8'd128, 39'd12355,        12'd2050, 1'b1, 1'b0, 39'd123,          1'b0, 1'b0, 16'd3},
    '{1'b0, 8'd130, 39'd100000000000, 12'd2048, 1'b0, 1'b0, 39'd549755813887, 1'b1, 1'b0, 16'd3},
    '{1'b0, 8'd129, 39'd100000000000, 12'd2048, 1'b1, 1'b0, 39'd450244186112, 1'b0, 1'b0, 16'd2},
    '{1'b0, 8'd129, 39'd100000000000, 12'd2048, 1'b1, 1'b1, 39'd450244186112, 1'b0, 1'b1, 16'd2},
    '{1'b0, 8'd130, 39'd5,            12'd2048, 1'b0, 1'b1, 39'd500,          1'b0, 1'b0, 16'd3},
    '{1'b0, 8'd128, 39'd3,            12'd2060, 1'b0, 1'b0, 39'd0,            1'b0, 1'b0, 16'd2},
    '{1'b0, 8'd128, 39'd5,            12'd2049, 1'b0, 1'b0, 39'd1,            1'b0, 1'b0, 16'd2},
    '{1'b0, 8'd128, 39'd1049,         12'd2050, 1'b0, 1'b0, 39'd10,           1'b0, 1'b0, 16'd3},
    '{1'b1, 8'd0,   39'd42,           12'd1918, 1'b0, 1'b0, 39'd4200,         1'b0, 1'b0, 16'd3},
    '{1'b0, 8'd255, 39'd40,           12'd2176, 1'b0, 1'b0, 39'd4,            1'b0, 1'b0, 16'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, in_sign, ext_mode, trap_en;
  logic [7:0]    in_exp;
  logic [MW-1:0] in_mant;
  logic [11:0]   tgt_exp;
  logic          out_sign, done, ovf, trap_req;
  logic [MW-1:0] out_mant;
  logic [11:0]   out_exp;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #2 clk = ~clk;

  dex_target_align u_dex_target_align (
    .clk(clk), .rst_n(rst_n), .start(start), .in_sign(in_sign),
    .in_exp(in_exp), .in_mant(in_mant), .tgt_exp(tgt_exp),
    .ext_mode(ext_mode), .trap_en(trap_en), .out_sign(out_sign),
    .out_mant(out_mant), .out_exp(out_exp), .done(done), .ovf(ovf),
    .trap_req(trap_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_sign  = v.sg;
    in_exp   = v.ex;
    in_mant  = v.mt;
    tgt_exp  = v.tg;
    ext_mode = v.ext;
    trap_en  = v.trp;
  endtask

  // waits for done, counting clocks after the start-sampling edge
  task automatic wait_done(output int cyc);
    cyc = 0;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      cyc++;
      if (done) break;
    end
  endtask

  task automatic report;
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int cyc;
    rst_n = 1'b0;
    start = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done",     64'(done),     64'd0);
    chk("R11 ovf",      64'(ovf),      64'd0);
    chk("R11 trap_req", 64'(trap_req), 64'd0);
    chk("R11 out_mant", 64'(out_mant), 64'd0);
    chk("R11 out_exp",  64'(out_exp),  64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk: R1..R9, R12
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(cyc);
      chk("R2 latency",     64'(cyc),      64'(VECS[i].ecyc));
      chk("R4 R5 R6 R7 R9 mantissa", 64'(out_mant), 64'(VECS[i].emt));
      chk("R1 exponent",    64'(out_exp),  64'(VECS[i].tg));
      chk("R6 ovf",         64'(ovf),      64'(VECS[i].eovf));
      chk("R8 trap_req",    64'(trap_req), 64'(VECS[i].etrp));
      chk("R12 sign",       64'(out_sign), 64'(VECS[i].sg));
      @(negedge clk);
      chk("R10 done pulse", 64'(done),     64'd0);
    end

    // R10: start while busy is ignored
    drive(VECS[1]);
    start = 1'b1;
    @(negedge clk);
    drive(VECS[9]);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    begin
      int c2;
      wait_done(c2);
      cyc += c2;
    end
    chk("R10 busy start latency", 64'(cyc),      64'd4);
    chk("R10 busy start mantissa", 64'(out_mant), 64'd7000);
    chk("R10 busy start exponent", 64'(out_exp),  64'd2048);
    repeat (3) begin
      @(negedge clk);
      chk("R10 no second done", 64'(done), 64'd0);
    end

    // R6: saturation flag holds after done until the next start
    drive(VECS[5]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    repeat (2) @(negedge clk);
    chk("R6 ovf held",     64'(ovf),      64'd1);
    chk("R6 saturated",    64'(out_mant), 64'(MAXM));
    report();
  end
endmodule